// File: doc/BRIEF.md
# Audio Slot Mono and Mute Handler

This block sits between the sample FIFO and the bit serializer of an audio port. It applies a per-slot data policy. When the port transmits, the block chooses the word for each slot as it starts. The word comes from one of three places: a fresh word taken from the FIFO, a word held from an earlier slot, or zero. This choice is how mono duplication and the two mute behaviours work.

When the port receives, each word from the serializer is passed on to the FIFO, except that the second slot is dropped in mono. The block also watches for frames in which every received slot was zero. When enough such frames arrive in a row, it sets a sticky mute-detected flag. Writing 1 to a clear input clears the flag. An interrupt output follows the flag, gated by an enable bit.

The serializer drives timing through three inputs: a slot-start strobe, a frame-end strobe and the current slot index. The slot count is a static configuration input.

Top module: `audio_slot_policy`

## Requirements
- R1: Mono behaviour (transmit duplication and receive discard) applies only when `slotCount` equals 2. With any other slot count, `cfgMono` has no effect.
- R2: In mono transmit, slot 1 sends the word that slot 0 sent in the same frame. No FIFO word is taken for slot 1 (`txPop` stays 0).
- R3: In mono receive, a word arriving in slot 1 is not passed on (`rxStore` stays 0). Words in slot 0 are passed on.
- R4: While transmit mute is on and `slotCount` is greater than 2, every slot sends 0. No FIFO word is taken while muted.
- R5: While transmit mute is on and `slotCount` is 2 or less, each slot sends 0 when `cfgMuteRepeat` is 0. When `cfgMuteRepeat` is 1, each slot sends the last unmuted word sent in that slot position.
- R6: Unmuted, non-duplicated transmit slots take one FIFO word. `txPop` is high combinationally in the `slotStart` cycle. The word appears on `txWord` with `txValid` high in the following cycle.
- R7: In receive mode, a frame counts as mute when every word received in it was zero. `muteFlag` sets at the frame end on which the run of consecutive mute frames reaches `cfgMuteCount` (a value of 0 never sets it). A frame with any nonzero word resets the run to 0.
- R8: `muteFlag` stays set until a `muteClear` pulse clears it. Once the run has reached the setting, more mute frames do not set the flag again until a nonzero frame has restarted the run.
- R9: `muteIrq` is high exactly while `muteFlag` and `cfgIrqEn` are both high.
- R10: After reset, `txValid`, `rxStore`, `muteFlag` and `muteIrq` are 0.
- R11: Frame ends in transmit mode (`cfgRxMode` = 0) do not change the mute run, and they never set `muteFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgRxMode | input | 1 | 1 = receive, 0 = transmit |
| cfgMono | input | 1 | Mono mode request |
| cfgMute | input | 1 | Transmit mute enable |
| cfgMuteRepeat | input | 1 | Muted slots resend the last word (1) or send zero (0) |
| cfgMuteCount | input | MCNT_W | Consecutive mute frames needed to set the flag |
| cfgIrqEn | input | 1 | Mute interrupt enable |
| muteClear | input | 1 | Write-1 clear of the mute flag |
| slotCount | input | SLOT_W+1 | Number of slots per frame |
| slotIdx | input | SLOT_W | Index of the current slot |
| slotStart | input | 1 | Transmit slot start strobe |
| frameEnd | input | 1 | Frame end strobe |
| fifoWord | input | DATA_W | Word offered by the transmit FIFO |
| txPop | output | 1 | Takes the offered FIFO word |
| txWord | output | DATA_W | Word for the serializer |
| txValid | output | 1 | txWord valid strobe |
| rxWord | input | DATA_W | Received slot word |
| rxValid | input | 1 | rxWord valid strobe |
| rxStore | output | 1 | Push strobe toward the receive FIFO |
| rxStoreWord | output | DATA_W | Word pushed toward the receive FIFO |
| muteFlag | output | 1 | Sticky mute-detected flag |
| muteIrq | output | 1 | Mute interrupt |

## Verification
The bench builds the block with 16-bit words and a 3-bit slot index, so slot counts up to 8 are possible. These sizes are enough to reach the 1-, 2-, 3- and 4-slot cases that separate mono and mute behaviour.

The mute count is set to 3. This makes the full path reachable in a few frames: building the run, resetting it with a nonzero frame, saturating it, clearing the flag and setting it again.

// File: rtl/slot_policy_pkg.sv
package slot_policy_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic txFire;   // produce a transmit word this cycle
    logic pop;      // take the FIFO word
    logic selLast;  // use a held word instead of zero
    logic lastRd;   // which held word to read
    logic updLast;  // write the produced word into a held slot
    logic lastWr;   // which held slot to write
    logic storeRx;  // pass the received word on
  } policy_ctrl_t;

endpackage

// File: rtl/slot_policy_control.sv
module slot_policy_control
  import slot_policy_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int MCNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxMode,
  input  logic              cfgMono,
  input  logic              cfgMute,
  input  logic              cfgMuteRepeat,
  input  logic [MCNT_W-1:0] cfgMuteCount,
  input  logic              cfgIrqEn,
  input  logic              muteClear,
  input  logic [SLOT_W:0]   slotCount,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              slotStart,
  input  logic              rxValid,
  input  logic              frameEnd,
  input  logic              frameMute,
  output policy_ctrl_t      ctrl,
  output logic              muteFlag,
  output logic              muteIrq
);
  localparam int COUNT_W = SLOT_W + 1;
  localparam logic [MCNT_W-1:0] RUN_MAX = {MCNT_W{1'b1}};

  logic monoOn, fewSlots, slotOne, slotLow;
  logic [MCNT_W-1:0] runCnt;
  logic atLimit, hitNow, rxFrameEnd;

  assign monoOn   = cfgMono && (slotCount == COUNT_W'(2));
  assign fewSlots = (slotCount <= COUNT_W'(2));
  assign slotOne  = (slotIdx == SLOT_W'(1));
  assign slotLow  = (slotIdx < SLOT_W'(2));

  always_comb begin
    ctrl = '0;
    if (slotStart && !cfgRxMode) begin
      ctrl.txFire = 1'b1;
      if (cfgMute) begin
        // held word only for short frames with repeat selected
        ctrl.selLast = fewSlots && cfgMuteRepeat;
        ctrl.lastRd  = slotIdx[0];
      end else if (monoOn && slotOne) begin
        ctrl.selLast = 1'b1;
        ctrl.lastRd  = 1'b0;
        ctrl.updLast = 1'b1;
        ctrl.lastWr  = 1'b1;
      end else begin
        ctrl.pop     = 1'b1;
        ctrl.updLast = slotLow;
        ctrl.lastWr  = slotIdx[0];
      end
    end
    ctrl.storeRx = rxValid && cfgRxMode && !(monoOn && slotOne);
  end

  // Consecutive mute-frame run and sticky flag
  assign rxFrameEnd = frameEnd && cfgRxMode;
  assign atLimit    = (runCnt == cfgMuteCount);
  assign hitNow     = rxFrameEnd && frameMute && !atLimit &&
                      (cfgMuteCount != '0) &&
                      ((runCnt + MCNT_W'(1)) == cfgMuteCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (rxFrameEnd) begin
      if (!frameMute)
        runCnt <= '0;
      else if (!atLimit && runCnt != RUN_MAX)
        runCnt <= runCnt + MCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          muteFlag <= 1'b0;
    else if (hitNow)    muteFlag <= 1'b1;
    else if (muteClear) muteFlag <= 1'b0;
  end

  assign muteIrq = muteFlag && cfgIrqEn;

endmodule

// File: rtl/slot_policy_datapath.sv
module slot_policy_datapath
  import slot_policy_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  policy_ctrl_t      ctrl,
  input  logic [DATA_W-1:0] fifoWord,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              rxValid,
  input  logic              frameEnd,
  output logic [DATA_W-1:0] txWord,
  output logic              txValid,
  output logic              rxStore,
  output logic [DATA_W-1:0] rxStoreWord,
  output logic              frameMute
);
  localparam int HELD = 2;

  logic [DATA_W-1:0] lastWord [HELD];
  logic [DATA_W-1:0] wordNext;
  logic              frameZero;
  logic              rxNonZero;

  always_comb begin
    if (ctrl.pop)          wordNext = fifoWord;
    else if (ctrl.selLast) wordNext = lastWord[ctrl.lastRd];
    else                   wordNext = '0;
  end

  for (genvar g = 0; g < HELD; g++) begin : gHeld
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lastWord[g] <= '0;
      else if (ctrl.updLast && (ctrl.lastWr == 1'(g)))
        lastWord[g] <= wordNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= ctrl.txFire;
      if (ctrl.txFire) txWord <= wordNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStore     <= 1'b0;
      rxStoreWord <= '0;
    end else begin
      rxStore <= ctrl.storeRx;
      if (ctrl.storeRx) rxStoreWord <= rxWord;
    end
  end

  // All-zero tracking across the current frame
  assign rxNonZero = rxValid && (rxWord != '0);
  assign frameMute = frameZero && !rxNonZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameZero <= 1'b1;
    else if (frameEnd)  frameZero <= 1'b1;
    else if (rxNonZero) frameZero <= 1'b0;
  end

endmodule

// File: rtl/audio_slot_policy.sv
module audio_slot_policy
  import slot_policy_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 4,
  parameter int MCNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxMode,
  input  logic              cfgMono,
  input  logic              cfgMute,
  input  logic              cfgMuteRepeat,
  input  logic [MCNT_W-1:0] cfgMuteCount,
  input  logic              cfgIrqEn,
  input  logic              muteClear,
  input  logic [SLOT_W:0]   slotCount,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic              slotStart,
  input  logic              frameEnd,
  input  logic [DATA_W-1:0] fifoWord,
  output logic              txPop,
  output logic [DATA_W-1:0] txWord,
  output logic              txValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              rxValid,
  output logic              rxStore,
  output logic [DATA_W-1:0] rxStoreWord,
  output logic              muteFlag,
  output logic              muteIrq
);
  policy_ctrl_t ctrl;
  logic         frameMute;

  slot_policy_control #(.SLOT_W(SLOT_W), .MCNT_W(MCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgRxMode(cfgRxMode), .cfgMono(cfgMono), .cfgMute(cfgMute),
    .cfgMuteRepeat(cfgMuteRepeat), .cfgMuteCount(cfgMuteCount),
    .cfgIrqEn(cfgIrqEn), .muteClear(muteClear),
    .slotCount(slotCount), .slotIdx(slotIdx), .slotStart(slotStart),
    .rxValid(rxValid), .frameEnd(frameEnd), .frameMute(frameMute),
    .ctrl(ctrl), .muteFlag(muteFlag), .muteIrq(muteIrq)
  );

  slot_policy_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .fifoWord(fifoWord), .rxWord(rxWord), .rxValid(rxValid),
    .frameEnd(frameEnd), .txWord(txWord), .txValid(txValid),
    .rxStore(rxStore), .rxStoreWord(rxStoreWord), .frameMute(frameMute)
  );

  assign txPop = ctrl.pop;

endmodule

// File: rtl/slot_policy_checker.sv
module slot_policy_checker #(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 4,
  parameter int MCNT_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgRxMode,
  input logic              cfgMono,
  input logic              cfgMute,
  input logic              cfgIrqEn,
  input logic              muteClear,
  input logic [SLOT_W:0]   slotCount,
  input logic [SLOT_W-1:0] slotIdx,
  input logic              slotStart,
  input logic              frameEnd,
  input logic              txPop,
  input logic [DATA_W-1:0] txWord,
  input logic              txValid,
  input logic              rxValid,
  input logic              rxStore,
  input logic              muteFlag,
  input logic              muteIrq
);
  localparam int COUNT_W = SLOT_W + 1;

  assert_tx_follows_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && !cfgRxMode) |=> txValid);

  assert_pop_needs_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (slotStart && !cfgRxMode));

  assert_mute_no_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMute && !cfgRxMode) |-> !txPop);

  assert_wide_mute_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && !cfgRxMode && cfgMute && slotCount > COUNT_W'(2)) |=> (txWord == '0));

  assert_mono_dup_no_pop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && !cfgRxMode && !cfgMute && cfgMono &&
     slotCount == COUNT_W'(2) && slotIdx == SLOT_W'(1)) |-> !txPop);

  assert_mono_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && cfgRxMode && cfgMono && slotCount == COUNT_W'(2) &&
     slotIdx == SLOT_W'(1)) |=> !rxStore);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (muteFlag && !muteClear) |=> muteFlag);

  assert_flag_rise_rx_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteFlag) |-> $past(frameEnd && cfgRxMode));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    muteIrq |-> (muteFlag && cfgIrqEn));

endmodule

bind audio_slot_policy slot_policy_checker #(
  .DATA_W(DATA_W), .SLOT_W(SLOT_W), .MCNT_W(MCNT_W)
) u_chk (.*);

// File: tb/sim_audio_slot_policy.sv
`timescale 1ns/1ps
module sim_audio_slot_policy;
  localparam int DW = 16;
  localparam int SW = 3;
  localparam int MW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRxMode = 0, cfgMono = 0, cfgMute = 0, cfgMuteRepeat = 0, cfgIrqEn = 0;
  logic [MW-1:0] cfgMuteCount = 6'd3;
  logic muteClear = 0, slotStart = 0, frameEnd = 0, rxValid = 0;
  logic [SW:0] slotCount = 4'd2;
  logic [SW-1:0] slotIdx = '0;
  logic [DW-1:0] fifoWord = '0, rxWord = '0;
  logic txPop, txValid, rxStore, muteFlag, muteIrq;
  logic [DW-1:0] txWord, rxStoreWord;

  int applied = 0;
  int failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_slot_policy #(.DATA_W(DW), .SLOT_W(SW), .MCNT_W(MW)) u0 (.*);

  typedef struct packed {
    logic mono; logic mute; logic rep;
    logic [3:0] slots; logic [2:0] idx;
    logic [15:0] word; logic pop; logic [15:0] expWord; logic [3:0] req;
  } vec_t;

  // Transmit vectors, applied in order (held words carry between rows)
  localparam vec_t VECS [18] = '{
    '{1'b0,1'b0,1'b0,4'd2,3'd0,16'hA101,1'b1,16'hA101,4'd6},  // R6 stereo
    '{1'b0,1'b0,1'b0,4'd2,3'd1,16'hB101,1'b1,16'hB101,4'd6},
    '{1'b1,1'b0,1'b0,4'd2,3'd0,16'hA202,1'b1,16'hA202,4'd2},  // R2 mono
    '{1'b1,1'b0,1'b0,4'd2,3'd1,16'hDEAD,1'b0,16'hA202,4'd2},
    '{1'b1,1'b0,1'b0,4'd4,3'd0,16'hC000,1'b1,16'hC000,4'd1},  // R1 mono ignored
    '{1'b1,1'b0,1'b0,4'd4,3'd1,16'hC111,1'b1,16'hC111,4'd1},
    '{1'b1,1'b0,1'b0,4'd4,3'd2,16'hC222,1'b1,16'hC222,4'd1},
    '{1'b1,1'b0,1'b0,4'd4,3'd3,16'hC333,1'b1,16'hC333,4'd1},
    '{1'b0,1'b1,1'b1,4'd2,3'd0,16'hDEAD,1'b0,16'hC000,4'd5},  // R5 repeat
    '{1'b0,1'b1,1'b1,4'd2,3'd1,16'hDEAD,1'b0,16'hC111,4'd5},
    '{1'b0,1'b1,1'b0,4'd2,3'd0,16'hDEAD,1'b0,16'h0000,4'd5},  // R5 zero
    '{1'b0,1'b1,1'b0,4'd2,3'd1,16'hDEAD,1'b0,16'h0000,4'd5},
    '{1'b0,1'b1,1'b1,4'd4,3'd2,16'hDEAD,1'b0,16'h0000,4'd4},  // R4 wide mute
    '{1'b0,1'b1,1'b1,4'd4,3'd0,16'hDEAD,1'b0,16'h0000,4'd4},
    '{1'b0,1'b1,1'b1,4'd1,3'd0,16'hDEAD,1'b0,16'hC000,4'd5},  // R5 one slot
    '{1'b1,1'b1,1'b1,4'd2,3'd1,16'hDEAD,1'b0,16'hC111,4'd5},
    '{1'b1,1'b0,1'b0,4'd3,3'd1,16'hE111,1'b1,16'hE111,4'd1},  // R1 three slots
    '{1'b0,1'b0,1'b0,4'd2,3'd0,16'hD000,1'b1,16'hD000,4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rxSlot(input logic [SW-1:0] idx, input logic [DW-1:0] d,
                        input logic expStore, input string req);
    @(negedge clk);
    rxValid = 1; slotIdx = idx; rxWord = d;
    @(negedge clk);
    rxValid = 0;
    check(req, rxStore, expStore);
    if (expStore) check(req, rxStoreWord, d);
  endtask

  task automatic endFrame();
    @(negedge clk); frameEnd = 1;
    @(negedge clk); frameEnd = 0;
  endtask

  task automatic zeroFrame();
    @(negedge clk); rxValid = 1; slotIdx = 0; rxWord = 0;
    @(negedge clk); slotIdx = 1;
    @(negedge clk); rxValid = 0;
    endFrame();
  endtask

  task automatic liveFrame();
    @(negedge clk); rxValid = 1; slotIdx = 0; rxWord = 0;
    @(negedge clk); slotIdx = 1; rxWord = 16'h0040;
    @(negedge clk); rxValid = 0;
    endFrame();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 txValid", txValid, 0);
    check("R10 rxStore", rxStore, 0);
    check("R10 muteFlag", muteFlag, 0);
    check("R10 muteIrq", muteIrq, 0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      cfgMono = VECS[i].mono; cfgMute = VECS[i].mute; cfgMuteRepeat = VECS[i].rep;
      slotCount = VECS[i].slots; slotIdx = VECS[i].idx; fifoWord = VECS[i].word;
      slotStart = 1;
      #1;
      check($sformatf("R%0d pop v%0d", VECS[i].req, i), txPop, VECS[i].pop);
      @(negedge clk);
      slotStart = 0;
      check($sformatf("R%0d valid v%0d", VECS[i].req, i), txValid, 1);
      check($sformatf("R%0d word v%0d", VECS[i].req, i), txWord, VECS[i].expWord);
    end
    cfgMute = 0; cfgMuteRepeat = 0;

    // R3 mono receive drop, R1 mono ignored with 4 slots
    cfgRxMode = 1; cfgMono = 1; slotCount = 2;
    rxSlot(0, 16'h1234, 1, "R3 slot0 kept");
    rxSlot(1, 16'h5678, 0, "R3 slot1 dropped");
    endFrame();
    slotCount = 4;
    rxSlot(1, 16'h2222, 1, "R1 rx slot1 kept");
    endFrame();
    cfgMono = 0; slotCount = 2;
    liveFrame();

    // R7 run of three zero frames
    cfgIrqEn = 1;
    zeroFrame(); zeroFrame();
    check("R7 two frames", muteFlag, 0);
    zeroFrame();
    check("R7 third frame", muteFlag, 1);
    check("R9 irq on", muteIrq, 1);
    cfgIrqEn = 0; #1;
    check("R9 irq masked", muteIrq, 0);
    cfgIrqEn = 1;

    // R8 clear and no re-fire while saturated
    @(negedge clk); muteClear = 1;
    @(negedge clk); muteClear = 0;
    check("R8 cleared", muteFlag, 0);
    zeroFrame(); zeroFrame(); zeroFrame(); zeroFrame();
    check("R8 no refire", muteFlag, 0);
    liveFrame();
    zeroFrame(); zeroFrame(); zeroFrame();
    check("R8 refire after live", muteFlag, 1);
    @(negedge clk); muteClear = 1;
    @(negedge clk); muteClear = 0;

    // R7 nonzero frame resets the run
    liveFrame();
    zeroFrame(); zeroFrame(); liveFrame(); zeroFrame(); zeroFrame();
    check("R7 run reset", muteFlag, 0);
    zeroFrame();
    check("R7 run complete", muteFlag, 1);
    @(negedge clk); muteClear = 1;
    @(negedge clk); muteClear = 0;

    // R11 frame ends in transmit mode leave the run alone
    liveFrame();
    cfgRxMode = 0;
    repeat (4) endFrame();
    check("R11 tx frames", muteFlag, 0);
    cfgRxMode = 1;
    zeroFrame(); zeroFrame();
    check("R11 run not advanced", muteFlag, 0);
    zeroFrame();
    check("R11 rx run fires", muteFlag, 1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule